// File: doc/BRIEF.md
# Idle Near-Memory Block Tracker

This block watches the traffic to a fast, small near memory and keeps a short list of blocks that have gone unused. When the near memory is full, the allocator asks the tracker for a block that can be pushed out, and the tracker answers with a block index or with a flag saying that no idle block is known.

Every block has one bit in an access bitmap. Any access sets that bit. A free-running period counter triggers a sweep at each period boundary. The sweep reads one bitmap word per cycle and copies up to `CAND_DEPTH` idle blocks into a small candidate table, lowest index first. It clears each word as it passes. Each candidate keeps its own touched bit and used bit. A candidate that is accessed after it was picked, or that has already been handed out, is never offered again. The next sweep rebuilds the table from scratch.

Top module: `idle_tracker`

## Requirements
- R1: Each block has one bitmap bit, and an access sets it. A block accessed at any time within a period, including during the sweep before its word is read, is not selected as a candidate at that period's boundary.
- R2: After reset a sweep starts every `PERIOD_CYCLES` cycles. It reads word w of `WORD_W` bits (blocks w*WORD_W to w*WORD_W+WORD_W-1) in the w-th cycle after the boundary. Before the first sweep the candidate table is empty.
- R3: A sweep selects at most `CAND_DEPTH` idle blocks, namely the ones with the lowest indices. Further idle blocks are dropped.
- R4: Each word is cleared as it is swept, so a block accessed in one period but idle in the next becomes a candidate at the next boundary.
- R5: An access to a candidate after it was selected, including an access during the sweep after its word was read, makes that candidate ineligible for the rest of the period.
- R6: A victim request is answered in the next cycle. When an eligible candidate exists, `vic_valid` pulses high and `vic_block` carries the eligible candidate with the lowest block index.
- R7: A candidate is handed out at most once per period.
- R8: When no eligible candidate exists, `vic_none` pulses high for one cycle in reply to the request. `vic_valid` and `vic_none` are never high together.
- R9: An access in the same cycle as a victim request excludes the accessed block from that reply and from all later replies in the period.
- R10: A synchronous active-high reset clears the bitmap, the candidate table, the period counter and both reply flags. A request straight after reset gets `vic_none`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_valid | input | 1 | An access to a near-memory block this cycle |
| acc_block | input | IDX_W | Index of the accessed block |
| vic_req | input | 1 | Request for one eviction victim |
| vic_valid | output | 1 | Registered: a victim is returned this cycle |
| vic_none | output | 1 | Registered: no eligible victim exists |
| vic_block | output | IDX_W | Registered victim block index, meaningful with `vic_valid` |

## Verification
The bench builds the tracker with 256 blocks in 16-bit words, an 8-entry table and a 512-cycle period. This is small enough to touch every block by hand within a single period and to run three full sweeps in a few thousand cycles. Ten idle blocks against eight slots exercise the truncation to the lowest indices. A short 16-cycle sweep makes it easy to aim an access at the moment just after a word has been read. The tight table depth also makes it cheap to drain the table completely and reach the no-victim reply.

// File: rtl/idle_pkg.sv
package idle_pkg;
  typedef enum logic {
    PH_RUN   = 1'b0,
    PH_SWEEP = 1'b1
  } phase_e;
endpackage

// File: rtl/idle_period_ctl.sv
module idle_period_ctl
  import idle_pkg::*;
#(
  parameter int PERIOD = 1000000,
  parameter int NWORDS = 64,
  parameter int PER_W  = 20,
  parameter int WP_W   = 6
) (
  input  logic            clk,
  input  logic            rst,
  output logic            start,
  output logic            sweeping,
  output logic [WP_W-1:0] wp
);
  logic [PER_W-1:0] cnt;
  phase_e           ph;

  assign start    = (cnt == PER_W'(PERIOD - 1));
  assign sweeping = (ph == PH_SWEEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      ph  <= PH_RUN;
      wp  <= '0;
    end else begin
      cnt <= start ? '0 : cnt + 1'b1;
      if (start) begin
        ph <= PH_SWEEP;
        wp <= '0;
      end else if (ph == PH_SWEEP) begin
        if (wp == WP_W'(NWORDS - 1)) ph <= PH_RUN;
        wp <= wp + 1'b1;
      end
    end
  end
endmodule

// File: rtl/idle_bitmap.sv
module idle_bitmap #(
  parameter int NWORDS = 64,
  parameter int WORD_W = 16,
  parameter int WP_W   = 6,
  parameter int BIT_W  = 4,
  parameter int IDX_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic [IDX_W-1:0]  acc_block,
  input  logic              sweeping,
  input  logic [WP_W-1:0]   wp,
  output logic [WORD_W-1:0] scan_word
);
  logic [WORD_W-1:0] mem [NWORDS];
  logic [WP_W-1:0]   acc_word;
  logic [BIT_W-1:0]  acc_bit;
  logic [WORD_W-1:0] acc_mask;

  assign acc_word = acc_block[IDX_W-1:BIT_W];
  assign acc_bit  = acc_block[BIT_W-1:0];
  assign acc_mask = acc_valid ? (WORD_W'(1) << acc_bit) : '0;

  // word under the sweep, with an access of this very cycle folded in
  assign scan_word = mem[wp] | ((acc_word == wp) ? acc_mask : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < NWORDS; w++) mem[w] <= '0;
    end else begin
      for (int w = 0; w < NWORDS; w++) begin
        if (sweeping && (wp == WP_W'(w))) begin
          mem[w] <= (acc_word == WP_W'(w)) ? acc_mask : '0;
        end else if (acc_word == WP_W'(w)) begin
          mem[w] <= mem[w] | acc_mask;
        end
      end
    end
  end
endmodule

// File: rtl/idle_cand_table.sv
module idle_cand_table #(
  parameter int L      = 64,
  parameter int IDX_W  = 10,
  parameter int WORD_W = 16,
  parameter int BIT_W  = 4,
  parameter int WP_W   = 6,
  parameter int CNT_W  = 7,
  parameter int RK_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              sweeping,
  input  logic [WP_W-1:0]   wp,
  input  logic [WORD_W-1:0] scan_word,
  input  logic              acc_valid,
  input  logic [IDX_W-1:0]  acc_block,
  input  logic              vic_req,
  output logic              vic_valid,
  output logic              vic_none,
  output logic [IDX_W-1:0]  vic_block
);
  logic [IDX_W-1:0]  blk [L];
  logic [L-1:0]      valid, touched, used;
  logic [CNT_W-1:0]  fill, fill_nx;
  logic [WORD_W-1:0] zmask;
  logic [RK_W-1:0]   rank [WORD_W];
  logic [RK_W-1:0]   nz;
  logic [L-1:0]      ins_hit, touch, elig, pick_oh;
  logic [IDX_W-1:0]  ins_blk [L];
  logic              found;
  logic [IDX_W-1:0]  pick_blk;

  assign zmask = sweeping ? ~scan_word : '0;

  // rank of each idle bit among the idle bits below it
  always_comb begin
    int run;
    run = 0;
    for (int j = 0; j < WORD_W; j++) begin
      rank[j] = RK_W'(run);
      if (zmask[j]) run = run + 1;
    end
    nz = RK_W'(run);
  end

  // compaction: idle bit of rank r goes to slot fill+r
  always_comb begin
    for (int s = 0; s < L; s++) begin
      ins_hit[s] = 1'b0;
      ins_blk[s] = '0;
      for (int j = 0; j < WORD_W; j++) begin
        if (zmask[j] && (int'(fill) + int'(rank[j]) == s)) begin
          ins_hit[s] = 1'b1;
          ins_blk[s] = {wp, BIT_W'(j)};
        end
      end
    end
  end

  always_comb begin
    int sum;
    sum = int'(fill) + int'(nz);
    fill_nx = (sum > L) ? CNT_W'(L) : CNT_W'(sum);
  end

  // eligibility and lowest-slot pick
  always_comb begin
    found    = 1'b0;
    pick_blk = '0;
    for (int s = 0; s < L; s++) begin
      touch[s]   = acc_valid && valid[s] && (blk[s] == acc_block);
      elig[s]    = valid[s] && !touched[s] && !used[s] && !touch[s];
      pick_oh[s] = 1'b0;
      if (!found && elig[s]) begin
        found      = 1'b1;
        pick_oh[s] = 1'b1;
        pick_blk   = blk[s];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid     <= '0;
      touched   <= '0;
      used      <= '0;
      fill      <= '0;
      vic_valid <= 1'b0;
      vic_none  <= 1'b0;
      vic_block <= '0;
      for (int s = 0; s < L; s++) blk[s] <= '0;
    end else begin
      vic_valid <= vic_req && found;
      vic_none  <= vic_req && !found;
      if (vic_req && found) vic_block <= pick_blk;
      if (clr) begin
        valid   <= '0;
        touched <= '0;
        used    <= '0;
        fill    <= '0;
      end else begin
        if (sweeping) fill <= fill_nx;
        for (int s = 0; s < L; s++) begin
          if (ins_hit[s]) begin
            blk[s]     <= ins_blk[s];
            valid[s]   <= 1'b1;
            touched[s] <= 1'b0;
            used[s]    <= 1'b0;
          end else begin
            if (touch[s]) touched[s] <= 1'b1;
            if (vic_req && pick_oh[s]) used[s] <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/idle_tracker.sv
module idle_tracker #(
  parameter int NUM_BLOCKS    = 1024,
  parameter int WORD_W        = 16,
  parameter int CAND_DEPTH    = 64,
  parameter int PERIOD_CYCLES = 1000000,
  localparam int IDX_W  = $clog2(NUM_BLOCKS),
  localparam int NWORDS = NUM_BLOCKS / WORD_W,
  localparam int WP_W   = $clog2(NWORDS),
  localparam int BIT_W  = $clog2(WORD_W),
  localparam int CNT_W  = $clog2(CAND_DEPTH + 1),
  localparam int RK_W   = $clog2(WORD_W + 1),
  localparam int PER_W  = $clog2(PERIOD_CYCLES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_valid,
  input  logic [IDX_W-1:0] acc_block,
  input  logic             vic_req,
  output logic             vic_valid,
  output logic             vic_none,
  output logic [IDX_W-1:0] vic_block
);
  logic              start, sweeping;
  logic [WP_W-1:0]   wp;
  logic [WORD_W-1:0] scan_word;

  idle_period_ctl #(
    .PERIOD(PERIOD_CYCLES), .NWORDS(NWORDS), .PER_W(PER_W), .WP_W(WP_W)
  ) u_ctl (
    .clk(clk), .rst(rst), .start(start), .sweeping(sweeping), .wp(wp)
  );

  idle_bitmap #(
    .NWORDS(NWORDS), .WORD_W(WORD_W), .WP_W(WP_W), .BIT_W(BIT_W), .IDX_W(IDX_W)
  ) u_map (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_block(acc_block),
    .sweeping(sweeping), .wp(wp), .scan_word(scan_word)
  );

  idle_cand_table #(
    .L(CAND_DEPTH), .IDX_W(IDX_W), .WORD_W(WORD_W), .BIT_W(BIT_W),
    .WP_W(WP_W), .CNT_W(CNT_W), .RK_W(RK_W)
  ) u_tab (
    .clk(clk), .rst(rst), .clr(start), .sweeping(sweeping), .wp(wp),
    .scan_word(scan_word), .acc_valid(acc_valid), .acc_block(acc_block),
    .vic_req(vic_req), .vic_valid(vic_valid), .vic_none(vic_none),
    .vic_block(vic_block)
  );
endmodule

// File: rtl/idle_tracker_chk.sv
module idle_tracker_chk #(
  parameter int IDX_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             acc_valid,
  input logic [IDX_W-1:0] acc_block,
  input logic             vic_req,
  input logic             vic_valid,
  input logic             vic_none,
  input logic [IDX_W-1:0] vic_block
);
  AST_SINGLE_REPLY: assert property (@(posedge clk) disable iff (rst)
    !(vic_valid && vic_none)); // R8

  AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (rst)
    vic_req |=> (vic_valid || vic_none)); // R6

  AST_NO_UNASKED_REPLY: assert property (@(posedge clk) disable iff (rst)
    (vic_valid || vic_none) |-> $past(vic_req)); // R8

  AST_SAME_CYCLE_EXCLUDED: assert property (@(posedge clk) disable iff (rst)
    (vic_req && acc_valid) |=> !(vic_valid && (vic_block == $past(acc_block)))); // R9

  AST_NO_REPEAT: assert property (@(posedge clk) disable iff (rst)
    (vic_valid && $past(vic_valid)) |-> (vic_block != $past(vic_block))); // R7
endmodule

bind idle_tracker idle_tracker_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_block(acc_block),
  .vic_req(vic_req), .vic_valid(vic_valid), .vic_none(vic_none),
  .vic_block(vic_block)
);

// File: tb/idle_tracker_bench.sv
module idle_tracker_bench;
  localparam int NB  = 256;
  localparam int WW  = 16;
  localparam int LD  = 8;
  localparam int PER = 512;
  localparam int NW  = NB / WW;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       acc_valid = 1'b0;
  logic [7:0] acc_block = '0;
  logic       vic_req = 1'b0;
  logic       vic_valid, vic_none;
  logic [7:0] vic_block;

  int n_chk = 0;
  int n_bad = 0;
  int edges = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (rst) edges <= 0;
    else     edges <= edges + 1;
  end

  idle_tracker #(
    .NUM_BLOCKS(NB), .WORD_W(WW), .CAND_DEPTH(LD), .PERIOD_CYCLES(PER)
  ) u_idle_tracker (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_block(acc_block),
    .vic_req(vic_req), .vic_valid(vic_valid), .vic_none(vic_none),
    .vic_block(vic_block)
  );

  // {req, acc, acc_blk[8], exp_valid, exp_none, exp_blk[8], tag[4]}
  localparam logic [23:0] VEC [10] = '{
    {1'b0, 1'b1, 8'd17,  1'b0, 1'b0, 8'd0,   4'd5},  // R5 touch candidate 17
    {1'b1, 1'b1, 8'd3,   1'b1, 1'b0, 8'd5,   4'd9},  // R9 head 3 excluded
    {1'b1, 1'b0, 8'd0,   1'b1, 1'b0, 8'd40,  4'd5},  // R5 17 skipped
    {1'b1, 1'b0, 8'd0,   1'b1, 1'b0, 8'd41,  4'd6},  // R6
    {1'b1, 1'b0, 8'd0,   1'b1, 1'b0, 8'd100, 4'd6},  // R6
    {1'b1, 1'b0, 8'd0,   1'b1, 1'b0, 8'd200, 4'd3},  // R3
    {1'b1, 1'b0, 8'd0,   1'b1, 1'b0, 8'd201, 4'd3},  // R3 250,255 dropped
    {1'b1, 1'b0, 8'd0,   1'b0, 1'b1, 8'd0,   4'd8},  // R8
    {1'b1, 1'b0, 8'd0,   1'b0, 1'b1, 8'd0,   4'd7},  // R7 nothing reissued
    {1'b0, 1'b0, 8'd0,   1'b0, 1'b0, 8'd0,   4'd8}   // R8 none lasts one cycle
  };

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic wait_until(input int n);
    while (edges < n) @(negedge clk);
  endtask

  task automatic step(input bit rq, input bit av, input int ab, input bit ev,
                      input bit en, input int eb, input string tag);
    vic_req   = rq;
    acc_valid = av;
    acc_block = 8'(ab);
    @(posedge clk);
    @(negedge clk);
    vic_req   = 1'b0;
    acc_valid = 1'b0;
    check(vic_valid == ev, tag, "vic_valid", int'(vic_valid), int'(ev));
    check(vic_none == en, tag, "vic_none", int'(vic_none), int'(en));
    if (ev) check(vic_block == 8'(eb), tag, "vic_block", int'(vic_block), eb);
  endtask

  task automatic touch(input int b);
    acc_valid = 1'b1;
    acc_block = 8'(b);
    @(posedge clk);
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  function automatic bit idle1(input int b);
    return b == 3 || b == 5 || b == 17 || b == 40 || b == 41 || b == 100 ||
           b == 200 || b == 201 || b == 250 || b == 255;
  endfunction

  function automatic bit idle2(input int b);
    return b == 7 || b == 128 || b == 129;
  endfunction

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(vic_valid == 1'b0, "R10", "vic_valid in reset", int'(vic_valid), 0);
    check(vic_none == 1'b0, "R10", "vic_none in reset", int'(vic_none), 0);
    rst = 1'b0;
    step(1, 0, 0, 0, 1, 0, "R10");

    // period 1: every block touched except the idle1 set (R1)
    for (int b = 0; b < NB; b++) if (!idle1(b)) touch(b);
    step(1, 0, 0, 0, 1, 0, "R2");      // no sweep yet, table empty
    wait_until(PER + NW + 2);
    for (int i = 0; i < 10; i++) begin
      step(VEC[i][23], VEC[i][22], int'(VEC[i][21:14]), VEC[i][13], VEC[i][12],
           int'(VEC[i][11:4]), $sformatf("R%0d", VEC[i][3:0]));
    end

    // period 2: block 7 was busy before, idle now (R4, R1)
    for (int b = 0; b < NB; b++) if (!idle2(b)) touch(b);
    wait_until(2 * PER + NW + 2);
    step(1, 0, 0, 1, 0, 7,   "R4");
    step(1, 0, 0, 1, 0, 128, "R1");
    step(1, 0, 0, 1, 0, 129, "R6");
    step(1, 0, 0, 0, 1, 0,   "R8");

    // period 3: no traffic; block 0 touched right after its word is swept
    wait_until(3 * PER + 2);
    touch(0);
    wait_until(3 * PER + NW + 2);
    step(1, 0, 0, 1, 0, 1, "R5");
    step(1, 0, 0, 1, 0, 2, "R2");
    step(1, 0, 0, 1, 0, 3, "R3");

    // R10 reset drops the remaining candidates
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    step(1, 0, 0, 0, 1, 0, "R10");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule